// File: doc/BRIEF.md
# Byte Program Status Poller

This block models how a byte-wide nonvolatile store reports the progress of a single-byte program through ordinary reads. A host starts a program by presenting a target address and a data byte for one cycle. The block keeps that target and byte while an internal counter stands in for the program time. During that window, a read of the target address returns a status byte rather than the stored data. Bit 7 is the inverse of bit 7 of the byte being written. Bit 6 flips on every such read. Bits 5..0 show the current array contents. When the counter expires, the array byte takes the new value, the target is released and reads return plain array data. Bit 7 then matches the written value, which tells the host that the program has finished.

A program can only clear bits. It stores the bitwise AND of the old and new bytes. If the request tries to raise any bit from 0 to 1, the block raises a sticky error flag, never finishes and stops flipping bit 6, so a host that watches bit 6 can see the fault. Only reset clears this condition. Reset also returns every array byte to the erased value 0xFF. The reset input is asynchronous; its release is synchronised to the clock inside the block.

Top module: `pgm_poll_flags`

## Requirements
- R1: After reset, busy and prog_err are 0 and every array byte reads 0xFF.
- R2: A program request accepted while idle raises busy on the next clock, and busy then stays high for exactly PROG_CYCLES cycles when no error occurs.
- R3: While busy, a read of the target address returns on bit 7 the complement of bit 7 of the byte being programmed.
- R4: While busy and without error, bit 6 of successive reads of the target address alternates. When idle, bit 6 is plain array data.
- R5: While busy, a read of any other address returns that address's stored byte unchanged.
- R6: After completion, a read of the target returns the programmed byte (old AND new), so its bit 7 equals the written bit 7.
- R7: A program request made while busy has no effect: neither the stored data nor the busy duration changes.
- R8: A request that would turn a stored 0 bit into 1 sets prog_err on the next clock. Busy then stays high until reset, and the array is left unchanged.
- R9: With prog_err set, reads of the target keep returning the complemented bit 7, and bit 6 stays constant across reads.
- R10: rd_valid is high exactly one clock after rd_req, and rd_data is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_req | input | 1 | One-cycle program request |
| prog_addr | input | ADDR_W | Program target address |
| prog_data | input | 8 | Byte to program |
| rd_req | input | 1 | One-cycle read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Array byte or status byte |
| rd_valid | output | 1 | rd_data valid, one cycle after rd_req |
| busy | output | 1 | Program in progress or stuck on error |
| prog_err | output | 1 | Sticky 0-to-1 program attempt flag |

## Verification
If the latched target is wrong, a busy-time read either returns status at the wrong address or returns raw data at the right one. Either shows up in rd_data on the cycle after the read. A bad toggle register appears within two target reads, as a bit 6 that fails to alternate or that keeps moving after an error. Timer or completion faults change the busy run length or the byte read back just after busy falls, so they appear within PROG_CYCLES cycles of the request.

// File: rtl/pgm_poll_pkg.sv
package pgm_poll_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOGL_BIT = 6;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pgm_rst_sync.sv
module pgm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pgm_array.sv
module pgm_array
  import pgm_poll_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  byte_t             wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output byte_t             rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output byte_t             rdata_b
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  byte_t mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];

  AST_WRITE_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> ((wdata & ~mem_q[waddr]) == '0)); // R6
endmodule

// File: rtl/pgm_timer.sv
module pgm_timer #(
  parameter int unsigned CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int unsigned CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (start)                    cnt_n = LOAD;
    else if (run && cnt_q != '0)  cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign done = run && (cnt_q == '0);

  AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD); // R2
  AST_TIMER_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == LOAD)); // R2
endmodule

// File: rtl/pgm_status_fmt.sv
module pgm_status_fmt
  import pgm_poll_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic              tgt_bit7,
  input  logic              busy,
  input  logic              err,
  input  byte_t             arr_byte,
  output byte_t             rd_data,
  output logic              rd_valid
);
  logic  poll_hit;
  logic  tog_q, tog_n;
  byte_t data_q, data_n;
  logic  valid_q;

  assign poll_hit = rd_req && busy && (rd_addr == tgt_addr);

  always_comb begin
    data_n = data_q;
    tog_n  = tog_q;
    if (rd_req) begin
      data_n = arr_byte;
      if (poll_hit) begin
        data_n[POLL_BIT] = ~tgt_bit7;
        data_n[TOGL_BIT] = tog_q;
        if (!err) tog_n = ~tog_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      tog_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_req;
      if (rd_req) begin
        data_q <= data_n;
        tog_q  <= tog_n;
      end
    end
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;

  AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid); // R10
  AST_POLL_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    poll_hit |=> (rd_data[POLL_BIT] == ~$past(tgt_bit7))); // R3
  AST_TOGGLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> $stable(tog_q)); // R9
endmodule

// File: rtl/pgm_poll_flags.sv
module pgm_poll_flags
  import pgm_poll_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned PROG_CYCLES = 6250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_req,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              prog_err
);
  logic              rst_i_n;
  logic              busy_q, busy_n;
  logic              err_q, err_n;
  logic [ADDR_W-1:0] tgt_addr_q, tgt_addr_n;
  byte_t             tgt_data_q, tgt_data_n;
  logic              accept, raise_bit, done;
  byte_t             arr_a, arr_b;
  logic [ADDR_W-1:0] chk_addr;

  pgm_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  assign chk_addr  = busy_q ? tgt_addr_q : prog_addr;
  assign accept    = prog_req && !busy_q;
  assign raise_bit = |(prog_data & ~arr_b);

  always_comb begin
    busy_n     = busy_q;
    err_n      = err_q;
    tgt_addr_n = tgt_addr_q;
    tgt_data_n = tgt_data_q;
    if (accept) begin
      busy_n     = 1'b1;
      err_n      = raise_bit;
      tgt_addr_n = prog_addr;
      tgt_data_n = prog_data;
    end else if (done) begin
      busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      busy_q     <= 1'b0;
      err_q      <= 1'b0;
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
    end else begin
      busy_q     <= busy_n;
      err_q      <= err_n;
      tgt_addr_q <= tgt_addr_n;
      tgt_data_q <= tgt_data_n;
    end
  end

  pgm_timer #(.CYCLES(PROG_CYCLES)) i_timer (
    .clk(clk), .rst_n(rst_i_n), .start(accept),
    .run(busy_q && !err_q), .done(done)
  );

  pgm_array #(.ADDR_W(ADDR_W)) i_array (
    .clk(clk), .rst_n(rst_i_n),
    .we(done), .waddr(tgt_addr_q), .wdata(arr_b & tgt_data_q),
    .raddr_a(rd_addr), .rdata_a(arr_a),
    .raddr_b(chk_addr), .rdata_b(arr_b)
  );

  pgm_status_fmt #(.ADDR_W(ADDR_W)) i_fmt (
    .clk(clk), .rst_n(rst_i_n),
    .rd_req(rd_req), .rd_addr(rd_addr),
    .tgt_addr(tgt_addr_q), .tgt_bit7(tgt_data_q[POLL_BIT]),
    .busy(busy_q), .err(err_q), .arr_byte(arr_a),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assign busy     = busy_q;
  assign prog_err = err_q;

  AST_ERR_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_i_n)
    err_q |-> busy_q); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_i_n)
    err_q |=> err_q); // R8
  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_i_n)
    busy_q |=> ($stable(tgt_addr_q) && $stable(tgt_data_q))); // R7
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> !busy_q); // R2
endmodule

// File: tb/test_pgm_poll_flags.sv
module test_pgm_poll_flags;
  localparam int unsigned AW   = 8;
  localparam int unsigned PROG = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          prog_req;
  logic [AW-1:0] prog_addr;
  logic [7:0]    prog_data;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          rd_valid;
  logic          busy;
  logic          prog_err;

  always #4 clk = ~clk;

  pgm_poll_flags #(.ADDR_W(AW), .PROG_CYCLES(PROG)) i_pgm_poll_flags (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .prog_addr(prog_addr),
    .prog_data(prog_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .prog_err(prog_err)
  );

  typedef struct {
    logic [7:0] exp;
    logic [7:0] mask;
    string      tag;
  } exp_t;

  exp_t       sb_q[$];
  exp_t       cur;
  int         n_chk = 0;
  int         n_bad = 0;
  logic [7:0] last_rd = '0;
  int         run_len = 0;
  int         last_run = 0;

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare read results against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R10 unexpected rd_valid actual=%0h expected=none", rd_data);
      end else begin
        cur = sb_q.pop_front();
        last_rd = rd_data;
        if (cur.mask != 8'h00) begin
          n_chk++;
          if ((rd_data & cur.mask) != (cur.exp & cur.mask)) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h mask=%0h",
                     cur.tag, rd_data, cur.exp, cur.mask);
          end
        end
      end
    end
  end

  // busy run length monitor
  always @(negedge clk) begin
    if (busy) run_len++;
    else if (run_len != 0) begin
      last_run = run_len;
      run_len  = 0;
    end
  end

  task automatic do_read(input logic [AW-1:0] a, input logic [7:0] e,
                         input logic [7:0] m, input string tag);
    exp_t it;
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a;
    it.exp = e; it.mask = m; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic rd_get(input logic [AW-1:0] a, output logic [7:0] v);
    do_read(a, 8'h00, 8'h00, "R4");
    @(posedge clk);
    v = last_rd;
  endtask

  task automatic do_prog(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    prog_req = 1'b1; prog_addr = a; prog_data = d;
    @(negedge clk);
    prog_req = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    logic [7:0] v1, v2, v3;
    rst_n = 1'b0; prog_req = 1'b0; prog_addr = '0; prog_data = '0;
    rd_req = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(prog_err == 1'b0, "R1 prog_err", prog_err, 0);
    do_read(8'h00, 8'hFF, 8'hFF, "R1 addr 00");
    do_read(8'h05, 8'hFF, 8'hFF, "R1 addr 05");
    do_read(8'hFF, 8'hFF, 8'hFF, "R1 addr FF");

    // program 0x3C at 0x05 (written bit7 = 0)
    do_prog(8'h05, 8'h3C);
    check(busy == 1'b1, "R2 busy rises", busy, 1);
    do_read(8'h05, 8'hBF, 8'hBF, "R3 busy target bit7 inverted");
    do_read(8'h09, 8'hFF, 8'hFF, "R5 busy other address");
    rd_get(8'h05, v1);
    rd_get(8'h05, v2);
    check(v1[6] != v2[6], "R4 bit6 alternates", v2[6], ~v1[6]);
    check(v1[7] == 1'b1, "R10 rd_data with rd_valid", v1[7], 1);
    do_prog(8'h09, 8'h00);             // R7: request while busy
    wait_idle();
    @(negedge clk);
    check(last_run == PROG, "R2 R7 busy duration", last_run, PROG);
    do_read(8'h05, 8'h3C, 8'hFF, "R6 data after completion");
    do_read(8'h09, 8'hFF, 8'hFF, "R7 ignored request left data");
    rd_get(8'h05, v1);
    rd_get(8'h05, v2);
    check(v1 == v2, "R4 idle bit6 steady", v2, v1);

    // program 0xA5 at 0x80 (written bit7 = 1)
    do_prog(8'h80, 8'hA5);
    do_read(8'h80, 8'h3F, 8'hBF, "R3 busy target bit7 inverted (1)");
    wait_idle();
    do_read(8'h80, 8'hA5, 8'hFF, "R6 bit7 equals written");
    do_prog(8'h80, 8'h25);
    wait_idle();
    do_read(8'h80, 8'h25, 8'hFF, "R6 clear more bits");
    do_prog(8'h05, 8'h14);
    wait_idle();
    do_read(8'h05, 8'h14, 8'hFF, "R6 second program");

    // R8/R9 raise bit1 at 0x05 (stored 0x14)
    do_prog(8'h05, 8'h16);
    check(prog_err == 1'b1, "R8 error flag", prog_err, 1);
    do_read(8'h05, 8'h94, 8'hBF, "R9 bit7 inverted in error");
    rd_get(8'h05, v1);
    rd_get(8'h05, v2);
    rd_get(8'h05, v3);
    check((v1[6] == v2[6]) && (v2[6] == v3[6]), "R9 bit6 frozen", v3[6], v1[6]);
    repeat (PROG + 10) @(negedge clk);
    check(busy == 1'b1, "R8 busy stuck", busy, 1);
    do_read(8'h80, 8'h25, 8'hFF, "R5 other address in error");
    do_prog(8'h80, 8'h00);
    do_read(8'h80, 8'h25, 8'hFF, "R7 request ignored in error");

    // R1 reset clears everything
    do_reset();
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(prog_err == 1'b0, "R1 error after reset", prog_err, 0);
    do_read(8'h05, 8'hFF, 8'hFF, "R1 erased after reset");
    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R10 all reads returned", sb_q.size(), 0);

    report();
    $finish;
  end
endmodule